// File: doc/BRIEF.md
# Wormhole Crossbar Switch with Packet-Locked Output Allocation

This block is a square crossbar that forwards packets split into flits from any of its input ports to any of its output ports. The first flit of a packet names its destination output. Once that flit wins the output's arbiter, the input holds a lock on that output. The rest of the packet follows along the same path without further routing, and no other packet can take the output until the last flit has gone through. A packet of one flit passes through without taking a lock.

Each output has its own round-robin arbiter, its own flit multiplexer and a one-stage output register. It also keeps a claimed/free flag and a credit counter. The counter holds the number of free slots in the buffer on the far side of the output link. Every request is gated by that output's credit-derived ready. A flit therefore leaves its input only when a slot is known to be free downstream. Each accepted flit produces a one-cycle credit pulse back to the upstream sender of that input.

Top module: `wh_switch`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `out_valid`, `credit_up` and (with `in_valid` low) `in_ready` are all zero. Every output is free, and every credit counter holds `BUF_DEPTH`.
- R2: An input presenting a head or single flit is accepted (`in_ready` high in the same cycle as `in_valid`) when its destination output is free, has at least one credit and wins arbitration. The flit appears on that output's `out_flit` slice with `out_valid` high one clock later.
- R3: A flit is `{kind[1:0], dest[PORT_W-1:0], payload[DATA_W-1:0]}`, with kind values 00 head, 01 body, 10 tail and 11 single. The flit is forwarded bit-exact.
- R4: Body and tail flits of a locked input go to the output stored when its head was accepted, whatever their own dest field holds.
- R5: From the acceptance of a head flit until its tail flit is accepted, no head or single flit from another input is accepted for that output. In the cycle after the tail is accepted, a waiting head may be accepted.
- R6: A single flit does not lock its input or claim its output. In the next cycle, the same output may accept a head from another input, and the same input may send a head to a different output.
- R7: Contending heads for one output are served in round-robin order. After reset, the lowest index has priority, and priority then moves to the input just above the last head/single winner.
- R8: Each output's credit count starts at `BUF_DEPTH`, drops by one per flit sent and rises by one per `out_credit` pulse. No flit is sent to an output whose count is zero.
- R9: `credit_up[i]` pulses high for exactly one cycle, in the cycle after input i's flit is accepted.
- R10: An accepted flit appears on exactly one output, the one its arbiter granted. All other outputs keep `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NUM_PORTS | Flit present at each input |
| in_flit | input | NUM_PORTS*FLIT_W | Flit of each input, input i at slice i |
| in_ready | output | NUM_PORTS | Flit accepted this cycle |
| credit_up | output | NUM_PORTS | One-cycle credit return to each upstream sender |
| out_valid | output | NUM_PORTS | Registered flit valid per output |
| out_flit | output | NUM_PORTS*FLIT_W | Registered flit per output, output o at slice o |
| out_credit | input | NUM_PORTS | Credit pulse from the downstream buffer of each output |

## Verification
The bench sweeps every source and destination pair with single flits. It checks that the flit arrives bit-exact on one output only and that the credit pulse comes back on the right input. A switch that decoded the destination wrongly, or that broadcast into several output registers, would fail here. Body flits carry a wrong dest field on purpose. A design that re-routed body flits would scatter the packet. Another head waits on the claimed output, and a design that freed the output early, or late, would let that head in too soon or hold it one cycle too long. Credits are drained to zero and then returned one at a time, which catches counters that underflow or ignore returns. Three-way contention checks the rotation order.

// File: rtl/wh_pkg.sv
package wh_pkg;

  typedef enum logic [1:0] {
    FK_HEAD   = 2'b00,
    FK_BODY   = 2'b01,
    FK_TAIL   = 2'b10,
    FK_SINGLE = 2'b11
  } flit_kind_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wh_rr_arbiter.sv
module wh_rr_arbiter #(
  parameter int NUM_REQ = 4,
  localparam int IDX_W = wh_pkg::idx_width(NUM_REQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req,
  input  logic               adv,
  output logic [NUM_REQ-1:0] gnt
);

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0] win_idx;
  logic             found;

  always_comb begin
    gnt     = '0;
    found   = 1'b0;
    win_idx = '0;
    for (int k = 0; k < NUM_REQ; k++) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= NUM_REQ) idx = idx - NUM_REQ;
      if (!found && req[idx]) begin
        found    = 1'b1;
        gnt[idx] = 1'b1;
        win_idx  = IDX_W'(idx);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv && found) begin
      if (int'(win_idx) == NUM_REQ - 1) ptr_d = '0;
      else                              ptr_d = win_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

endmodule

// File: rtl/wh_input_ctrl.sv
module wh_input_ctrl #(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 8,
  localparam int PORT_W = wh_pkg::idx_width(NUM_PORTS),
  localparam int FLIT_W = 2 + PORT_W + DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid,
  input  logic [FLIT_W-1:0]    flit,
  input  logic [NUM_PORTS-1:0] out_ready,
  input  logic [NUM_PORTS-1:0] out_free,
  input  logic                 granted,
  output logic [NUM_PORTS-1:0] req,
  output logic                 dequeue,
  output logic                 credit_up,
  output logic                 locked,
  output logic [PORT_W-1:0]    lock_port
);
  import wh_pkg::*;

  flit_kind_e       kind;
  logic [PORT_W-1:0] dest, tgt;
  logic             lock_q, lock_d, lock_en;
  logic [PORT_W-1:0] port_q, port_d;
  logic             cup_q;

  assign kind = flit_kind_e'(flit[FLIT_W-1 -: 2]);
  assign dest = flit[FLIT_W-3 -: PORT_W];
  assign tgt  = lock_q ? port_q : dest;

  // request generation: locked inputs reuse the stored port, others need a free output
  always_comb begin
    req = '0;
    if (valid && (int'(tgt) < NUM_PORTS) && out_ready[tgt]) begin
      if (lock_q)
        req[tgt] = 1'b1;
      else if ((kind == FK_HEAD || kind == FK_SINGLE) && out_free[tgt])
        req[tgt] = 1'b1;
    end
  end

  assign dequeue = valid && granted;

  always_comb begin
    lock_en = dequeue;
    lock_d  = lock_q;
    port_d  = port_q;
    if (!lock_q && kind == FK_HEAD) begin
      lock_d = 1'b1;
      port_d = dest;
    end else if (lock_q && kind == FK_TAIL) begin
      lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      port_q <= '0;
    end else if (lock_en) begin
      lock_q <= lock_d;
      port_q <= port_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cup_q <= 1'b0;
    else        cup_q <= dequeue;
  end

  assign credit_up = cup_q;
  assign locked    = lock_q;
  assign lock_port = port_q;

endmodule

// File: rtl/wh_output_port.sv
module wh_output_port #(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 8,
  parameter int BUF_DEPTH = 4,
  localparam int PORT_W = wh_pkg::idx_width(NUM_PORTS),
  localparam int FLIT_W = 2 + PORT_W + DATA_W,
  localparam int CNT_W  = $clog2(BUF_DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        req,
  input  logic [NUM_PORTS*FLIT_W-1:0] flits,
  input  logic                        credit_in,
  output logic [NUM_PORTS-1:0]        gnt,
  output logic                        out_valid,
  output logic [FLIT_W-1:0]           out_flit,
  output logic                        free,
  output logic                        ready,
  output logic [CNT_W-1:0]            credits
);
  import wh_pkg::*;

  logic [FLIT_W-1:0] sel_flit;
  flit_kind_e        sel_kind;
  logic              sent, adv;
  logic              free_q, free_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              vld_q;
  logic [FLIT_W-1:0] flit_q;

  wh_rr_arbiter #(.NUM_REQ(NUM_PORTS)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .adv   (adv),
    .gnt   (gnt)
  );

  always_comb begin
    sel_flit = '0;
    for (int i = 0; i < NUM_PORTS; i++)
      if (gnt[i]) sel_flit = sel_flit | flits[i*FLIT_W +: FLIT_W];
  end

  assign sel_kind = flit_kind_e'(sel_flit[FLIT_W-1 -: 2]);
  assign sent     = |gnt;
  assign adv      = sent && (sel_kind == FK_HEAD || sel_kind == FK_SINGLE);

  always_comb begin
    free_d = free_q;
    if (sent && sel_kind == FK_HEAD) free_d = 1'b0;
    if (sent && sel_kind == FK_TAIL) free_d = 1'b1;
  end

  always_comb begin
    cnt_d = cnt_q - CNT_W'(sent) + CNT_W'(credit_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= 1'b1;
      cnt_q  <= CNT_W'(BUF_DEPTH);
      vld_q  <= 1'b0;
    end else begin
      free_q <= free_d;
      cnt_q  <= cnt_d;
      vld_q  <= sent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flit_q <= '0;
    else if (sent) flit_q <= sel_flit;
  end

  assign out_valid = vld_q;
  assign out_flit  = flit_q;
  assign free      = free_q;
  assign ready     = (cnt_q != '0);
  assign credits   = cnt_q;

endmodule

// File: rtl/wh_switch.sv
module wh_switch #(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 8,
  parameter int BUF_DEPTH = 4,
  localparam int PORT_W = wh_pkg::idx_width(NUM_PORTS),
  localparam int FLIT_W = 2 + PORT_W + DATA_W,
  localparam int CNT_W  = $clog2(BUF_DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        in_valid,
  input  logic [NUM_PORTS*FLIT_W-1:0] in_flit,
  output logic [NUM_PORTS-1:0]        in_ready,
  output logic [NUM_PORTS-1:0]        credit_up,
  output logic [NUM_PORTS-1:0]        out_valid,
  output logic [NUM_PORTS*FLIT_W-1:0] out_flit,
  input  logic [NUM_PORTS-1:0]        out_credit
);

  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] req_by_in, req_by_out;
  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] gnt_by_in, gnt_by_out;
  logic [NUM_PORTS-1:0]                out_free, out_rdy, in_locked;
  logic [NUM_PORTS*PORT_W-1:0]         lock_ports;
  logic [NUM_PORTS*CNT_W-1:0]          credit_cnts;

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_xpose_o
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_xpose_i
      assign req_by_out[o][i] = req_by_in[i][o];
      assign gnt_by_in[i][o]  = gnt_by_out[o][i];
    end
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_in
    wh_input_ctrl #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_in (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (in_valid[i]),
      .flit      (in_flit[i*FLIT_W +: FLIT_W]),
      .out_ready (out_rdy),
      .out_free  (out_free),
      .granted   (|gnt_by_in[i]),
      .req       (req_by_in[i]),
      .dequeue   (in_ready[i]),
      .credit_up (credit_up[i]),
      .locked    (in_locked[i]),
      .lock_port (lock_ports[i*PORT_W +: PORT_W])
    );
  end

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
    wh_output_port #(
      .NUM_PORTS (NUM_PORTS),
      .DATA_W    (DATA_W),
      .BUF_DEPTH (BUF_DEPTH)
    ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req_by_out[o]),
      .flits     (in_flit),
      .credit_in (out_credit[o]),
      .gnt       (gnt_by_out[o]),
      .out_valid (out_valid[o]),
      .out_flit  (out_flit[o*FLIT_W +: FLIT_W]),
      .free      (out_free[o]),
      .ready     (out_rdy[o]),
      .credits   (credit_cnts[o*CNT_W +: CNT_W])
    );
  end

endmodule

// File: rtl/wh_switch_chk.sv
module wh_switch_chk #(
  parameter int NUM_PORTS = 4,
  parameter int BUF_DEPTH = 4,
  localparam int PORT_W = wh_pkg::idx_width(NUM_PORTS),
  localparam int CNT_W  = $clog2(BUF_DEPTH + 1)
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [NUM_PORTS-1:0]              in_valid,
  input logic [NUM_PORTS-1:0]              in_ready,
  input logic [NUM_PORTS-1:0]              credit_up,
  input logic [NUM_PORTS-1:0]              out_valid,
  input logic [NUM_PORTS-1:0]              out_free,
  input logic [NUM_PORTS-1:0]              out_rdy,
  input logic [NUM_PORTS-1:0]              in_locked,
  input logic [NUM_PORTS*PORT_W-1:0]       lock_ports,
  input logic [NUM_PORTS*CNT_W-1:0]        credit_cnts,
  input logic [NUM_PORTS-1:0][NUM_PORTS-1:0] gnt_by_out
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_FLIT_CONSERVED: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $countones(out_valid) == $countones($past(in_valid & in_ready))); // R10

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_in_chk
    AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready[i] |-> in_valid[i]); // R2
    AST_CREDIT_RETURN: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      credit_up[i] == $past(in_valid[i] && in_ready[i])); // R9
  end

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out_chk
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      int'(credit_cnts[o*CNT_W +: CNT_W]) <= BUF_DEPTH); // R8
    AST_NO_SEND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      out_valid[o] |-> $past(out_rdy[o])); // R8
    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_by_out[o])); // R10
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_pair_chk
      AST_CLAIMED_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_free[o] && gnt_by_out[o][i]) |->
          (in_locked[i] && int'(lock_ports[i*PORT_W +: PORT_W]) == o)); // R5
    end
  end

endmodule

bind wh_switch wh_switch_chk #(
  .NUM_PORTS (NUM_PORTS),
  .BUF_DEPTH (BUF_DEPTH)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .credit_up   (credit_up),
  .out_valid   (out_valid),
  .out_free    (out_free),
  .out_rdy     (out_rdy),
  .in_locked   (in_locked),
  .lock_ports  (lock_ports),
  .credit_cnts (credit_cnts),
  .gnt_by_out  (gnt_by_out)
);

// File: tb/wh_switch_test.sv
`timescale 1ns/1ps
module wh_switch_test;
  localparam int N     = 3;
  localparam int DW    = 8;
  localparam int DEPTH = 3;
  localparam int PW    = 2;
  localparam int FW    = 2 + PW + DW;

  localparam logic [1:0] K_HEAD = 2'b00, K_BODY = 2'b01, K_TAIL = 2'b10, K_SINGLE = 2'b11;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n;
  logic [N-1:0]    in_valid;
  logic [N*FW-1:0] in_flit;
  logic [N-1:0]    in_ready, credit_up, out_valid, out_credit;
  logic [N*FW-1:0] out_flit;
  logic            cr_auto;
  logic [N-1:0]    cr_man;

  assign out_credit = cr_auto ? out_valid : cr_man;

  wh_switch #(.NUM_PORTS(N), .DATA_W(DW), .BUF_DEPTH(DEPTH)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_flit    (in_flit),
    .in_ready   (in_ready),
    .credit_up  (credit_up),
    .out_valid  (out_valid),
    .out_flit   (out_flit),
    .out_credit (out_credit)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk(input logic [1:0] k, input int d, input int p);
    return {k, PW'(d), DW'(p)};
  endfunction

  task automatic put(input int i, input logic [FW-1:0] f);
    in_valid[i] = 1'b1;
    in_flit[i*FW +: FW] = f;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [FW-1:0] oslice(input int o);
    return out_flit[o*FW +: FW];
  endfunction

  task automatic do_reset;
    rst_n = 1'b0; in_valid = '0; in_flit = '0; cr_auto = 1'b1; cr_man = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 out_valid in reset", 32'(out_valid), 0);
    rst_n = 1'b1;
    #1;
    check("R1 in_ready idle", 32'(in_ready), 0);
    step();
    check("R1 out_valid after release", 32'(out_valid), 0);
    check("R1 credit_up after release", 32'(credit_up), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    do_reset();

    // R2 R3 R9 R10: every source to every destination with single flits
    for (int s = 0; s < N; s++) begin
      for (int d = 0; d < N; d++) begin
        logic [FW-1:0] f;
        f = mk(K_SINGLE, d, s * 16 + d + 1);
        in_valid = '0;
        put(s, f);
        #1;
        check("R2 accept", 32'(in_ready), 32'(1 << s));
        step();
        in_valid = '0;
        #1;
        check("R10 single output", 32'(out_valid), 32'(1 << d));
        check("R3 flit exact", 32'(oslice(d)), 32'(f));
        check("R9 credit pulse", 32'(credit_up), 32'(1 << s));
      end
    end
    step();
    check("R9 pulse one cycle", 32'(credit_up), 0);

    // R4 R5: wormhole lock with a competing head
    do_reset();
    put(0, mk(K_HEAD, 2, 8'hA1));
    put(1, mk(K_HEAD, 2, 8'hB1));
    #1;
    check("R7 low index first", 32'(in_ready), 32'b001);
    step();
    check("R2 head out", 32'(out_valid), 32'b100);
    check("R3 head flit", 32'(oslice(2)), 32'(mk(K_HEAD, 2, 8'hA1)));
    put(0, mk(K_BODY, 0, 8'hA2));
    #1;
    check("R5 other head blocked", 32'(in_ready), 32'b001);
    step();
    check("R4 body follows lock", 32'(out_valid), 32'b100);
    check("R4 body flit", 32'(oslice(2)), 32'(mk(K_BODY, 0, 8'hA2)));
    put(0, mk(K_TAIL, 1, 8'hA3));
    #1;
    check("R5 blocked during tail", 32'(in_ready), 32'b001);
    step();
    check("R4 tail follows lock", 32'(out_valid), 32'b100);
    check("R4 tail flit", 32'(oslice(2)), 32'(mk(K_TAIL, 1, 8'hA3)));
    in_valid[0] = 1'b0;
    #1;
    check("R5 waiting head wins after tail", 32'(in_ready), 32'b010);
    step();
    check("R5 waiting head out", 32'(oslice(2)), 32'(mk(K_HEAD, 2, 8'hB1)));
    put(1, mk(K_TAIL, 2, 8'hB2));
    step();
    in_valid = '0;

    // R6: single flit leaves no lock
    do_reset();
    put(0, mk(K_SINGLE, 1, 8'hC1));
    #1;
    check("R6 single accepted", 32'(in_ready), 32'b001);
    step();
    put(0, mk(K_HEAD, 0, 8'hC2));
    put(1, mk(K_HEAD, 1, 8'hD1));
    #1;
    check("R6 no lock left", 32'(in_ready), 32'b011);
    step();
    check("R6 two outputs", 32'(out_valid), 32'b011);
    check("R6 out0 flit", 32'(oslice(0)), 32'(mk(K_HEAD, 0, 8'hC2)));
    check("R6 out1 flit", 32'(oslice(1)), 32'(mk(K_HEAD, 1, 8'hD1)));
    put(0, mk(K_TAIL, 2, 8'hC3));
    put(1, mk(K_TAIL, 2, 8'hD2));
    #1;
    check("R4 tails to locked ports", 32'(in_ready), 32'b011);
    step();
    check("R4 tails outputs", 32'(out_valid), 32'b011);
    in_valid = '0;

    // R7: three-way round-robin on output 0
    do_reset();
    for (int k = 0; k < 6; k++) begin
      int w;
      w = k % N;
      for (int i = 0; i < N; i++) put(i, mk(K_SINGLE, 0, k * 16 + i));
      #1;
      check("R7 rotation", 32'(in_ready), 32'(1 << w));
      step();
      check("R7 winner flit", 32'(oslice(0)), 32'(mk(K_SINGLE, 0, k * 16 + w)));
    end
    in_valid = '0;

    // R8: credits drain, then return one by one
    do_reset();
    cr_auto = 1'b0;
    for (int k = 0; k < 5; k++) begin
      put(0, mk(k == 0 ? K_HEAD : K_BODY, 1, k));
      #1;
      check("R8 credit gate", 32'(in_ready[0]), (k < DEPTH) ? 1 : 0);
      step();
    end
    check("R8 nothing sent at zero", 32'(out_valid), 0);
    cr_man[1] = 1'b1;
    #1;
    check("R8 credit not yet applied", 32'(in_ready[0]), 0);
    step();
    cr_man[1] = 1'b0;
    #1;
    check("R8 one credit one flit", 32'(in_ready[0]), 1);
    step();
    check("R8 flit out after credit", 32'(out_valid), 32'b010);
    check("R8 drained again", 32'(in_ready[0]), 0);
    in_valid = '0;
    for (int k = 0; k < DEPTH; k++) begin
      cr_man[1] = 1'b1;
      step();
    end
    cr_man[1] = 1'b0;
    begin
      int sent;
      sent = 0;
      for (int k = 0; k < DEPTH + 2; k++) begin
        put(0, mk(K_BODY, 1, 8'h40 + k));
        #1;
        if (in_ready[0]) sent++;
        step();
      end
      check("R8 refilled to depth", 32'(sent), 32'(DEPTH));
    end
    in_valid = '0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule